// File: doc/BRIEF.md
# I2C Controller Host Register Bank

This block is the byte-wide register front end of an I2C master controller. A host issues single-byte writes and reads on a small address space. The block turns those accesses into stored configuration (a clock prescaler, a control byte and a transmit byte) and into one-cycle command strobes for the separate bit-level transfer engine. It also returns the engine's received byte and its live status flags. The prescaler occupies two byte addresses, loaded low byte first and then high byte. Two other addresses each carry a write-only register and a read-only register: the data address holds transmit data on write and receive data on read, and the command address holds the command on write and the status on read.

The enable bit in the control byte switches between a setup phase and normal operation. In the setup phase the prescaler can be changed and commands are refused. In normal operation the prescaler is frozen and commands are accepted. The engine raises a completion strobe after each byte or bus condition it finishes, and that strobe sets a sticky interrupt flag. An acknowledge bit in the command byte clears the flag. The interrupt line is the flag gated by the interrupt-enable bit.

Top module: `i2c_regbank`

## Requirements
- R1: After synchronous reset the prescaler is 0xFFFF, the control byte reads 0x00, the interrupt flag is 0, and every command strobe, cmd_nack and irq are 0.
- R2: Byte addresses 0 and 1 are the prescaler low and high bytes, 2 is control, 3 is data and 4 is command/status. Addresses 5 to 7 read as 0x00, and writes to them change no register.
- R3: A write to address 0 or 1 loads that prescaler byte only while control bit 7 (enable) is 0. While enable is 1 the prescaler keeps its value.
- R4: Control bit 7 is enable, bit 6 is interrupt enable and bit 5 is master mode, and all three read back as written. Bits 4 to 0 read as zero. ctl_en and ctl_master follow bits 7 and 5.
- R5: A write to address 3 loads tx_data. A read of address 3 returns eng_rx_data.
- R6: A write to address 4 while enable is 1 produces a one-cycle strobe in the cycle after the write: bit 7 drives cmd_start, bit 6 cmd_stop, bit 5 cmd_read and bit 4 cmd_write. While enable is 0, command writes are ignored.
- R7: A command write that is accepted with bit 5 (read) and bit 3 (NACK) both set raises cmd_nack in the same cycle as cmd_read. cmd_nack then stays high until the next accepted command write.
- R8: A read of address 4 returns status: bit 7 eng_rx_nack, bit 6 eng_busy, bit 5 eng_arb_lost, bit 1 eng_tip and bit 0 the interrupt flag. Bits 4 to 2 read as zero.
- R9: eng_done sets the interrupt flag in the next cycle. An accepted command write with bit 0 set clears the flag. If eng_done arrives in the same cycle as the clear, the flag stays set.
- R10: irq is high exactly when the interrupt flag and control bit 6 are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Byte address |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| prescale | output | 16 | Clock prescaler to the engine |
| ctl_en | output | 1 | Normal-operation enable |
| ctl_master | output | 1 | Master mode select |
| tx_data | output | 8 | Byte to transmit |
| cmd_start | output | 1 | Start-condition strobe |
| cmd_stop | output | 1 | Stop-condition strobe |
| cmd_read | output | 1 | Read-byte strobe |
| cmd_write | output | 1 | Write-byte strobe |
| cmd_nack | output | 1 | Answer the read byte with NACK |
| eng_rx_data | input | 8 | Byte received by the engine |
| eng_done | input | 1 | Engine finished a byte or condition |
| eng_rx_nack | input | 1 | Slave answered NACK |
| eng_busy | input | 1 | Bus busy |
| eng_arb_lost | input | 1 | Arbitration lost |
| eng_tip | input | 1 | Transfer in progress |
| irq | output | 1 | Level interrupt |

## Verification
The bench tries a prescaler write after enable is set. A bank that is not locked would change the divider while a transfer runs. It sends commands in the setup phase, where a bank without command gating would start a bus transaction while the prescaler is still unset. It raises the completion strobe in the same cycle as an acknowledge write, and a design that gives the clear priority would lose that completion event. It also drops interrupt-enable while the flag is set and sends a read-with-NACK command followed by a write command. These catch an irq that is not gated and a NACK bit that is cleared at the wrong time.

// File: rtl/i2c_rb_pkg.sv
package i2c_rb_pkg;

    localparam int unsigned BYTE_W = 8;

    // Decoded fields of an accepted command byte
    typedef struct packed {
        logic start;
        logic stop;
        logic rd;
        logic wr;
        logic nack;
        logic iack;
    } cmd_req_t;

    // Stored control bits
    typedef struct packed {
        logic en;
        logic ien;
        logic mst;
    } ctrl_t;

    // Status byte as seen by the host, bit 7 down to bit 0
    typedef struct packed {
        logic rx_nack;
        logic busy;
        logic arb_lost;
        logic [2:0] zero;
        logic tip;
        logic flag;
    } stat_t;

    function automatic logic [BYTE_W-1:0] ctrl_byte(ctrl_t c);
        return {c.en, c.ien, c.mst, 5'b0};
    endfunction

endpackage

// File: rtl/i2c_rb_prescale.sv
module i2c_rb_prescale #(
    parameter int unsigned PS_W = 16,
    parameter int unsigned ADDR_W = 3,
    parameter logic [PS_W-1:0] RESET_VAL = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              unlocked,
    output logic [PS_W-1:0]   prescale
);
    localparam int unsigned PS_BYTES = PS_W / 8;

    for (genvar g = 0; g < PS_BYTES; g++) begin : g_byte
        always_ff @(posedge clk) begin
            if (rst)
                prescale[g*8 +: 8] <= RESET_VAL[g*8 +: 8];
            else if (wr_en && unlocked && addr == ADDR_W'(g))
                prescale[g*8 +: 8] <= wdata;
        end
    end

    // R3: prescaler frozen while the bank is in normal operation
    p_locked_r3: assert property (@(posedge clk) disable iff (rst)
        !unlocked |=> $stable(prescale));

endmodule

// File: rtl/i2c_rb_cmd.sv
module i2c_rb_cmd
    import i2c_rb_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_cmd,
    input  logic     accept,
    input  cmd_req_t req,
    output logic     cmd_start,
    output logic     cmd_stop,
    output logic     cmd_read,
    output logic     cmd_write,
    output logic     cmd_nack,
    output logic     iack
);
    logic go;
    assign go   = wr_cmd && accept;
    assign iack = go && req.iack;

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_start <= 1'b0;
            cmd_stop  <= 1'b0;
            cmd_read  <= 1'b0;
            cmd_write <= 1'b0;
            cmd_nack  <= 1'b0;
        end else begin
            cmd_start <= go && req.start;
            cmd_stop  <= go && req.stop;
            cmd_read  <= go && req.rd;
            cmd_write <= go && req.wr;
            if (go)
                cmd_nack <= req.rd && req.nack;
        end
    end

    // R6: no strobe follows a cycle in which commands were refused
    p_gated_r6: assert property (@(posedge clk) disable iff (rst)
        !accept |=> !(cmd_start || cmd_stop || cmd_read || cmd_write));

    // R7: a new NACK request only arrives together with a read strobe
    p_nack_with_read_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(cmd_nack) |-> cmd_read);

endmodule

// File: rtl/i2c_rb_irq.sv
module i2c_rb_irq (
    input  logic clk,
    input  logic rst,
    input  logic done,
    input  logic clear,
    input  logic ien,
    output logic flag,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (done)
            flag <= 1'b1;
        else if (clear)
            flag <= 1'b0;
    end

    assign irq = flag && ien;

    // R9: a completion is never lost, even against a clear
    p_done_sets_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> flag);

    p_clear_r9: assert property (@(posedge clk) disable iff (rst)
        (clear && !done) |=> !flag);

endmodule

// File: rtl/i2c_regbank.sv
module i2c_regbank
    import i2c_rb_pkg::*;
#(
    parameter int unsigned ADDR_W = 3,
    parameter int unsigned PS_W = 16,
    parameter logic [PS_W-1:0] PS_RESET = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [PS_W-1:0]   prescale,
    output logic              ctl_en,
    output logic              ctl_master,
    output logic [7:0]        tx_data,
    output logic              cmd_start,
    output logic              cmd_stop,
    output logic              cmd_read,
    output logic              cmd_write,
    output logic              cmd_nack,
    input  logic [7:0]        eng_rx_data,
    input  logic              eng_done,
    input  logic              eng_rx_nack,
    input  logic              eng_busy,
    input  logic              eng_arb_lost,
    input  logic              eng_tip,
    output logic              irq
);
    localparam int unsigned PS_BYTES = PS_W / 8;
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(PS_BYTES);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(PS_BYTES + 1);
    localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(PS_BYTES + 2);

    ctrl_t    ctrl_q;
    cmd_req_t req;
    stat_t    stat;
    logic     iack;
    logic     flag;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            tx_data <= '0;
        end else if (bus_wr) begin
            if (bus_addr == A_CTRL)
                ctrl_q <= '{en: bus_wdata[7], ien: bus_wdata[6], mst: bus_wdata[5]};
            if (bus_addr == A_DATA)
                tx_data <= bus_wdata;
        end
    end

    assign ctl_en     = ctrl_q.en;
    assign ctl_master = ctrl_q.mst;

    assign req = '{start: bus_wdata[7], stop: bus_wdata[6], rd: bus_wdata[5],
                   wr: bus_wdata[4], nack: bus_wdata[3], iack: bus_wdata[0]};

    i2c_rb_prescale #(.PS_W(PS_W), .ADDR_W(ADDR_W), .RESET_VAL(PS_RESET)) i_prescale (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (bus_wr),
        .addr     (bus_addr),
        .wdata    (bus_wdata),
        .unlocked (!ctrl_q.en),
        .prescale (prescale)
    );

    i2c_rb_cmd i_cmd (
        .clk       (clk),
        .rst       (rst),
        .wr_cmd    (bus_wr && bus_addr == A_CMD),
        .accept    (ctrl_q.en),
        .req       (req),
        .cmd_start (cmd_start),
        .cmd_stop  (cmd_stop),
        .cmd_read  (cmd_read),
        .cmd_write (cmd_write),
        .cmd_nack  (cmd_nack),
        .iack      (iack)
    );

    i2c_rb_irq i_irq (
        .clk   (clk),
        .rst   (rst),
        .done  (eng_done),
        .clear (iack),
        .ien   (ctrl_q.ien),
        .flag  (flag),
        .irq   (irq)
    );

    assign stat = '{rx_nack: eng_rx_nack, busy: eng_busy, arb_lost: eng_arb_lost,
                    zero: 3'b000, tip: eng_tip, flag: flag};

    always_comb begin
        bus_rdata = '0;
        for (int i = 0; i < PS_BYTES; i++)
            if (bus_addr == ADDR_W'(i))
                bus_rdata = prescale[i*8 +: 8];
        if (bus_addr == A_CTRL) bus_rdata = ctrl_byte(ctrl_q);
        if (bus_addr == A_DATA) bus_rdata = eng_rx_data;
        if (bus_addr == A_CMD)  bus_rdata = stat;
    end

    // R10: the interrupt line needs interrupt enable
    p_irq_gate_r10: assert property (@(posedge clk) disable iff (rst)
        irq |-> bus_rdata != 8'h00 || bus_addr != A_CTRL);

    // R6: a strobe only ever follows an accepted command write
    p_strobe_src_r6: assert property (@(posedge clk) disable iff (rst)
        (cmd_start || cmd_stop || cmd_read || cmd_write) |->
        $past(bus_wr && bus_addr == A_CMD && ctrl_q.en));

endmodule

// File: tb/test_i2c_regbank.sv
module test_i2c_regbank;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [15:0] prescale;
    logic       ctl_en, ctl_master;
    logic [7:0] tx_data;
    logic       cmd_start, cmd_stop, cmd_read, cmd_write, cmd_nack;
    logic [7:0] eng_rx_data = 8'hC3;
    logic       eng_done = 1'b0;
    logic       eng_rx_nack = 1'b0;
    logic       eng_busy = 1'b0;
    logic       eng_arb_lost = 1'b0;
    logic       eng_tip = 1'b0;
    logic       irq;

    int checks = 0;
    int fails = 0;

    always #10 clk = ~clk;  // 50 MHz

    i2c_regbank i_i2c_regbank (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .prescale(prescale),
        .ctl_en(ctl_en), .ctl_master(ctl_master), .tx_data(tx_data),
        .cmd_start(cmd_start), .cmd_stop(cmd_stop), .cmd_read(cmd_read),
        .cmd_write(cmd_write), .cmd_nack(cmd_nack), .eng_rx_data(eng_rx_data),
        .eng_done(eng_done), .eng_rx_nack(eng_rx_nack), .eng_busy(eng_busy),
        .eng_arb_lost(eng_arb_lost), .eng_tip(eng_tip), .irq(irq)
    );

    // {req number[3:0], addr[2:0], wdata[7:0], expected readback[7:0]}
    localparam logic [22:0] VEC [8] = '{
        {4'd3, 3'd0, 8'h34, 8'h34},  // R3 low byte while unlocked
        {4'd3, 3'd1, 8'h12, 8'h12},  // R3 high byte while unlocked
        {4'd4, 3'd2, 8'h1F, 8'h00},  // R4 low control bits read zero
        {4'd4, 3'd2, 8'h60, 8'h60},  // R4 ien and master, enable kept 0
        {4'd5, 3'd3, 8'h5A, 8'hC3},  // R5 read returns receive byte
        {4'd2, 3'd5, 8'h77, 8'h00},  // R2 unmapped address
        {4'd2, 3'd7, 8'hFF, 8'h00},  // R2 unmapped address
        {4'd6, 3'd4, 8'h80, 8'h00}   // R6 refused command, status idle
    };

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, output logic [7:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1", "prescale", prescale, 16'hFFFF);
        rd(3'd2, r);
        chk("R1", "control", {8'h0, r}, 16'h0000);
        rd(3'd4, r);
        chk("R1", "status", {8'h0, r}, 16'h0000);
        chk("R1", "strobes", {11'h0, cmd_start, cmd_stop, cmd_read, cmd_write, cmd_nack}, 16'h0);
        chk("R1", "irq", {15'h0, irq}, 16'h0);

        for (int i = 0; i < 8; i++) begin
            wr(VEC[i][18:16], VEC[i][15:8]);
            if (VEC[i][18:16] == 3'd4)
                chk("R6", "start while disabled", {15'h0, cmd_start}, 16'h0);
            rd(VEC[i][18:16], r);
            chk($sformatf("R%0d", VEC[i][22:19]), $sformatf("vector %0d", i),
                {8'h0, r}, {8'h0, VEC[i][7:0]});
        end
        chk("R3", "prescale port", prescale, 16'h1234);
        chk("R5", "tx_data", {8'h0, tx_data}, 16'h005A);
        chk("R2", "control after unmapped", {8'h0, ctl_en, 1'b0, ctl_master, 5'h0}, 16'h0020);

        // R4 enable normal operation
        wr(3'd2, 8'hE0);
        chk("R4", "ctl_en/master", {14'h0, ctl_en, ctl_master}, 16'h3);
        // R3 locked prescaler
        wr(3'd0, 8'h00);
        wr(3'd1, 8'h99);
        chk("R3", "prescale locked", prescale, 16'h1234);

        // R6 start strobe lasts one cycle
        wr(3'd4, 8'h80);
        chk("R6", "start pulse", {12'h0, cmd_start, cmd_stop, cmd_read, cmd_write}, 16'h8);
        @(negedge clk);
        chk("R6", "start cleared", {12'h0, cmd_start, cmd_stop, cmd_read, cmd_write}, 16'h0);
        wr(3'd4, 8'h40);
        chk("R6", "stop pulse", {12'h0, cmd_start, cmd_stop, cmd_read, cmd_write}, 16'h4);

        // R7 NACK held with the read
        wr(3'd4, 8'h28);
        chk("R7", "read+nack", {14'h0, cmd_read, cmd_nack}, 16'h3);
        @(negedge clk);
        chk("R7", "nack held", {14'h0, cmd_read, cmd_nack}, 16'h1);
        wr(3'd4, 8'h10);
        chk("R7", "nack dropped on write", {14'h0, cmd_write, cmd_nack}, 16'h2);

        // R8 status fields
        eng_rx_nack = 1'b1; eng_busy = 1'b1; eng_tip = 1'b1;
        rd(3'd4, r);
        chk("R8", "status live", {8'h0, r}, 16'h00C2);
        eng_arb_lost = 1'b1; eng_busy = 1'b0;
        rd(3'd4, r);
        chk("R8", "status arb", {8'h0, r}, 16'h00A2);

        // R9 / R10 interrupt flag and line
        eng_done = 1'b1;
        @(negedge clk);
        eng_done = 1'b0;
        rd(3'd4, r);
        chk("R9", "flag set", {15'h0, r[0]}, 16'h1);
        chk("R10", "irq on", {15'h0, irq}, 16'h1);
        wr(3'd2, 8'hA0);
        chk("R10", "irq masked", {15'h0, irq}, 16'h0);
        rd(3'd4, r);
        chk("R10", "flag kept when masked", {15'h0, r[0]}, 16'h1);
        wr(3'd2, 8'hE0);
        chk("R10", "irq back", {15'h0, irq}, 16'h1);
        wr(3'd4, 8'h01);
        rd(3'd4, r);
        chk("R9", "flag cleared", {8'h0, r}, 16'h00A2);
        chk("R10", "irq off after clear", {15'h0, irq}, 16'h0);

        // R9 completion wins over a simultaneous clear
        @(negedge clk);
        eng_done = 1'b1;
        wr(3'd4, 8'h01);
        eng_done = 1'b0;
        rd(3'd4, r);
        chk("R9", "done beats clear", {15'h0, r[0]}, 16'h1);

        // R6 / R9 acknowledge refused while disabled
        wr(3'd2, 8'h40);
        wr(3'd4, 8'h01);
        rd(3'd4, r);
        chk("R9", "clear refused when disabled", {15'h0, r[0]}, 16'h1);
        chk("R10", "irq with ien only", {15'h0, irq}, 16'h1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule